// File: doc/BRIEF.md
# Multi-Function Pad Controller

This block controls a single external pad. A 32-bit control register, written and read over a simple register port, decides which of up to eight internal peripheral functions owns the pad's data and output enable. The same register sets where the pad's pulls come from and which drive strength and slew code goes out to the pad cell. It can also replace the pad's output value and enable while the chip is in a low-power state.

The pad input passes through a two-flop synchronizer. A detector watches the synchronized value for rising edges, falling edges or both, and records any hit in a sticky pending bit. That bit becomes a wakeup request only while the external wake enable for the pad's group is high. Register writes take effect on the clock edge that samples them. The pad-side outputs follow from the register and the run-time inputs without any further register stage.

Top module: `pad_mux_ctrl`

## Requirements
- R1: After a synchronous active-low reset, reg_rdata reads 0x0000_0800 (function 0, drive code 2, no sleep override, edge detection off, pulls taken from the function), pad_drive is 2, and edge_pending and wake_req are 0.
- R2: Control bits 2:0 select the function index whose func_out and func_oe bits drive pad_out and pad_oe. This holds whenever bit 9 is clear or lpm_active is low.
- R3: With bit 9 set and lpm_active high, pad_oe equals the inverse of bit 7 and pad_out equals bit 8, whatever the selected function drives.
- R4: With bit 15 clear, pad_pu and pad_pd follow func_pu and func_pd of the selected function. With bit 15 set, bit 14 requests the pull-up and bit 13 requests the pull-down.
- R5: When the pull-up and pull-down are both requested by either source, pad_pd is 1 and pad_pu is 0.
- R6: pad_drive equals control bits 12:10 and changes on the same edge as the register value.
- R7: Bit 4 enables detection of rising edges and bit 5 enables detection of falling edges on pad_in. A detected edge sets edge_pending on the third clock edge after pad_in changes, and edge_pending then stays 1 until it is cleared.
- R8: While bit 6 is set, no edge is detected, and edge_pending goes to 0 on the clock edge after bit 6 is first seen set.
- R9: wake_req is 1 exactly when edge_pending and wake_en are both 1.
- R10: Bit 3 and bits 31:16 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the control register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control register value |
| func_out | input | NUM_FUNC | Data from each peripheral function |
| func_oe | input | NUM_FUNC | Output enable from each function |
| func_pu | input | NUM_FUNC | Pull-up request from each function |
| func_pd | input | NUM_FUNC | Pull-down request from each function |
| lpm_active | input | 1 | Chip is in low-power mode |
| pad_in | input | 1 | Raw pad input level |
| wake_en | input | 1 | Wake enable for this pad's group |
| pad_out | output | 1 | Data to the pad |
| pad_oe | output | 1 | Output enable to the pad |
| pad_pu | output | 1 | Pull-up enable |
| pad_pd | output | 1 | Pull-down enable |
| pad_drive | output | 3 | Drive strength and slew code |
| edge_pending | output | 1 | Sticky edge-detected status |
| wake_req | output | 1 | Wakeup request |

## Verification
A register write is visible on reg_rdata, pad_drive and the pad mux outputs one clock edge after the strobe is sampled. Changes on the function, lpm_active and wake_en inputs reach pad_out, pad_oe, the pulls and wake_req within the same cycle. A pad_in change shows up on edge_pending on the third edge, and a clear reaches it one edge after the clear bit is registered. The driver applies each stimulus on a falling edge and then waits exactly those counts of falling edges before it queues its expectations. The monitor compares them 1 ns later, and checks placed one edge early confirm that no result comes too soon.

// File: rtl/pad_mux_pkg.sv
// Package: shared control-register layout for the multi-function pad
// controller. Field positions are fixed by the register map and are relied
// on by software, so they are not parameters.
package pad_mux_pkg;

    localparam int REG_W = 32;

    // Bits that hold state; all others read zero (bit 3, bits 31:16).
    localparam logic [REG_W-1:0] CFG_WMASK = 32'h0000_FFF7;

    // Reset: function 0, drive code 2 (fast 3 mA), everything else off.
    localparam logic [REG_W-1:0] CFG_RESET = 32'h0000_0800;

    // Decoded view of the low half of the control register.
    typedef struct packed {
        logic       pull_src;   // 15: 1 = register pulls, 0 = function pulls
        logic       pu_req;     // 14
        logic       pd_req;     // 13
        logic [2:0] drive;      // 12:10
        logic       slp_ovr;    // 9: override pad in low-power mode
        logic       slp_data;   // 8
        logic       slp_oe_n;   // 7: active low
        logic       edge_clr;   // 6
        logic       fall_en;    // 5
        logic       rise_en;    // 4
        logic       rsvd;       // 3
        logic [2:0] func_sel;   // 2:0
    } pad_cfg_t;

endpackage

// File: rtl/pad_cfg_reg.sv
// Module: pad_cfg_reg
// Holds the 32-bit pad control register. Reserved bits are masked on write,
// so they always read zero. Assumes a single-cycle write strobe and
// no read side effects.
module pad_cfg_reg
    import pad_mux_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output pad_cfg_t         cfg
);

    logic [REG_W-1:0] cfg_q;

    // Register update: masked write, synchronous reset to defaults.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= CFG_RESET;
        else if (wr_en)
            cfg_q <= wdata & CFG_WMASK;
    end

    // Read-back and decoded view.
    always_comb begin
        rdata = cfg_q;
        cfg   = pad_cfg_t'(cfg_q[15:0]);
    end

    // R10: reserved bits never hold a one.
    p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[31:16] == 16'h0) && !rdata[3]);

    // R10: a write changes the register only through its writable bits.
    p_write_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rdata == ($past(wdata) & CFG_WMASK)));

endmodule

// File: rtl/pad_out_path.sv
// Module: pad_out_path
// Combinational pad output path: function mux, low-power override and
// pull-source selection with pull-down priority. Assumes NUM_FUNC <= 8.
// An index at or above NUM_FUNC selects an idle function (all zero).
module pad_out_path
    import pad_mux_pkg::*;
#(
    parameter int NUM_FUNC = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  pad_cfg_t            cfg,
    input  logic [NUM_FUNC-1:0] func_out,
    input  logic [NUM_FUNC-1:0] func_oe,
    input  logic [NUM_FUNC-1:0] func_pu,
    input  logic [NUM_FUNC-1:0] func_pd,
    input  logic                lpm_active,
    output logic                pad_out,
    output logic                pad_oe,
    output logic                pad_pu,
    output logic                pad_pd
);

    logic [NUM_FUNC-1:0] sel_hot;
    logic sel_out, sel_oe, sel_pu, sel_pd;
    logic want_pu, want_pd, sleep_take;

    // One-hot decode of the function select, one bit per function.
    genvar gi;
    generate
        for (gi = 0; gi < NUM_FUNC; gi++) begin : g_dec
            assign sel_hot[gi] = (cfg.func_sel == 3'(gi));
        end
    endgenerate

    // AND-OR mux of the selected function's signals.
    always_comb begin
        sel_out = |(sel_hot & func_out);
        sel_oe  = |(sel_hot & func_oe);
        sel_pu  = |(sel_hot & func_pu);
        sel_pd  = |(sel_hot & func_pd);
    end

    // Low-power override of data and enable.
    always_comb begin
        sleep_take = cfg.slp_ovr && lpm_active;
        pad_out    = sleep_take ? cfg.slp_data  : sel_out;
        pad_oe     = sleep_take ? !cfg.slp_oe_n : sel_oe;
    end

    // Pull source choice; pull-down wins when both are requested.
    always_comb begin
        want_pu = cfg.pull_src ? cfg.pu_req : sel_pu;
        want_pd = cfg.pull_src ? cfg.pd_req : sel_pd;
        pad_pd  = want_pd;
        pad_pu  = want_pu && !want_pd;
    end

    // R5: the two pulls are never on together.
    p_pull_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pad_pu && pad_pd));

    // R3: under override the pad follows the register, not the function.
    p_sleep_ovr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.slp_ovr && lpm_active) |-> (pad_oe == !cfg.slp_oe_n) && (pad_out == cfg.slp_data));

endmodule

// File: rtl/pad_edge_detect.sv
// Module: pad_edge_detect
// Synchronizes the raw pad input, detects enabled rising/falling edges on
// the synchronized value and keeps a sticky pending flag. The clear input
// dominates: it blocks detection and empties the flag. Assumes pad_in
// may be fully asynchronous to clk.
module pad_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_in,
    input  logic rise_en,
    input  logic fall_en,
    input  logic clr,
    output logic pending
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;
    logic cur, prev, hit;

    // Synchronizer stages plus one history flop.
    genvar si;
    generate
        for (si = 0; si < CHAIN_W; si++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain_q[si] <= 1'b0;
                else if (si == 0)
                    chain_q[si] <= pad_in;
                else
                    chain_q[si] <= chain_q[(si == 0) ? 0 : si-1];
            end
        end
    endgenerate

    // Edge qualification against the enables.
    always_comb begin
        cur  = chain_q[SYNC_STAGES-1];
        prev = chain_q[SYNC_STAGES];
        hit  = (rise_en && cur && !prev) || (fall_en && !cur && prev);
    end

    // Sticky pending flag, cleared by clr.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (clr)
            pending <= 1'b0;
        else if (hit)
            pending <= 1'b1;
    end

    // R8: clear empties the flag on the next edge.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pending);

    // R7: the flag is sticky while not cleared.
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clr) |=> pending);

    // R7: the flag rises only after a qualifying edge.
    p_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(hit));

endmodule

// File: rtl/pad_mux_ctrl.sv
// Module: pad_mux_ctrl (top)
// Per-pad control unit: control register, function/sleep output path,
// pull and drive attributes, edge detector and gated wakeup request.
// Assumes one pad per instance; address decoding lives outside.
module pad_mux_ctrl
    import pad_mux_pkg::*;
#(
    parameter int NUM_FUNC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_FUNC-1:0] func_out,
    input  logic [NUM_FUNC-1:0] func_oe,
    input  logic [NUM_FUNC-1:0] func_pu,
    input  logic [NUM_FUNC-1:0] func_pd,
    input  logic                lpm_active,
    input  logic                pad_in,
    input  logic                wake_en,
    output logic                pad_out,
    output logic                pad_oe,
    output logic                pad_pu,
    output logic                pad_pd,
    output logic [2:0]          pad_drive,
    output logic                edge_pending,
    output logic                wake_req
);

    pad_cfg_t cfg;

    pad_cfg_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    pad_out_path #(.NUM_FUNC(NUM_FUNC)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .func_out   (func_out),
        .func_oe    (func_oe),
        .func_pu    (func_pu),
        .func_pd    (func_pd),
        .lpm_active (lpm_active),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .pad_pu     (pad_pu),
        .pad_pd     (pad_pd)
    );

    pad_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_in  (pad_in),
        .rise_en (cfg.rise_en),
        .fall_en (cfg.fall_en),
        .clr     (cfg.edge_clr),
        .pending (edge_pending)
    );

    // Drive code straight out; wakeup gated by the group enable.
    always_comb begin
        pad_drive = cfg.drive;
        wake_req  = edge_pending && wake_en;
    end

    // R9: wakeup only with the group enable and a pending edge.
    p_wake_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (wake_en && edge_pending));

    // R6: drive code tracks the register field seen on the read port.
    p_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pad_drive == reg_rdata[12:10]);

endmodule

// File: tb/pad_mux_ctrl_tb_top.sv
// Scoreboard bench: the driver applies stimulus on falling edges, waits the
// documented latency and queues expected values; a monitor pops them and
// compares against the ports 1 ns after each falling edge.
module pad_mux_ctrl_tb_top;

    localparam int NF = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [31:0]   reg_wdata = 32'h0;
    logic [31:0]   reg_rdata;
    logic [NF-1:0] func_out = '0, func_oe = '0, func_pu = '0, func_pd = '0;
    logic          lpm_active = 1'b0, pad_in = 1'b0, wake_en = 1'b0;
    logic          pad_out, pad_oe, pad_pu, pad_pd, edge_pending, wake_req;
    logic [2:0]    pad_drive;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string       req;
        string       what;
        int          sel;
        logic [31:0] exp;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;  // 50 MHz

    pad_mux_ctrl #(.NUM_FUNC(NF), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .func_out(func_out), .func_oe(func_oe),
        .func_pu(func_pu), .func_pd(func_pd), .lpm_active(lpm_active),
        .pad_in(pad_in), .wake_en(wake_en), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_drive(pad_drive),
        .edge_pending(edge_pending), .wake_req(wake_req)
    );

    function automatic logic [31:0] observe(int sel);
        case (sel)
            0: return reg_rdata;
            1: return {31'h0, pad_out};
            2: return {31'h0, pad_oe};
            3: return {31'h0, pad_pu};
            4: return {31'h0, pad_pd};
            5: return {29'h0, pad_drive};
            6: return {31'h0, edge_pending};
            default: return {31'h0, wake_req};
        endcase
    endfunction

    task automatic expect_val(string req, string what, int sel, logic [31:0] v);
        item_t it;
        it.req = req; it.what = what; it.sel = sel; it.exp = v;
        sb_q.push_back(it);
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [31:0] d);
        reg_wr_en = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Monitor: pop and compare everything queued for this sample point.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = observe(it.sel);
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s %s actual=0x%08h expected=0x%08h",
                             it.req, it.what, act, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        cyc(100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Driver.
    initial begin
        func_out = 8'h01; func_oe = 8'h01;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        expect_val("R1", "rdata", 0, 32'h0000_0800);
        expect_val("R1", "drive", 5, 32'd2);
        expect_val("R1", "pending", 6, 0);
        expect_val("R1", "wake", 7, 0);
        expect_val("R1", "out f0", 1, 1);
        expect_val("R1", "oe f0", 2, 1);
        cyc(1);

        // R2 function select
        func_out = 8'b1010_0000; func_oe = 8'b0010_0000;
        wr(32'h0000_0805);
        expect_val("R2", "out sel5", 1, 1);
        expect_val("R2", "oe sel5", 2, 1);
        wr(32'h0000_0807);
        expect_val("R2", "out sel7", 1, 1);
        expect_val("R2", "oe sel7", 2, 0);
        wr(32'h0000_0806);
        expect_val("R2", "out sel6", 1, 0);
        expect_val("R2", "oe sel6", 2, 0);

        // R6 drive code
        wr(32'h0000_1C00);
        expect_val("R6", "drive 7", 5, 32'd7);
        expect_val("R6", "rdata", 0, 32'h0000_1C00);
        wr(32'h0000_1000);
        expect_val("R6", "drive 4", 5, 32'd4);

        // R10 reserved bits
        wr(32'hFFFF_FFFF);
        expect_val("R10", "rdata all ones", 0, 32'h0000_FFF7);
        wr(32'hFFFF_0008);
        expect_val("R10", "rdata rsvd only", 0, 32'h0000_0000);

        // R3 sleep override
        func_out = 8'h01; func_oe = 8'h01;
        wr(32'h0000_0280);
        expect_val("R3", "run out", 1, 1);
        expect_val("R3", "run oe", 2, 1);
        cyc(1);
        lpm_active = 1'b1;
        cyc(1);
        expect_val("R3", "lpm out", 1, 0);
        expect_val("R3", "lpm oe", 2, 0);
        wr(32'h0000_0300);
        expect_val("R3", "lpm out hi", 1, 1);
        expect_val("R3", "lpm oe on", 2, 1);
        func_out = 8'h00;
        wr(32'h0000_0100);
        expect_val("R2", "lpm no ovr out", 1, 0);
        expect_val("R2", "lpm no ovr oe", 2, 1);
        cyc(1);
        lpm_active = 1'b0;

        // R4 pull source
        func_pu = 8'h01; func_pd = 8'h00;
        wr(32'h0000_0000);
        expect_val("R4", "func pu", 3, 1);
        expect_val("R4", "func pd", 4, 0);
        wr(32'h0000_A000);
        expect_val("R4", "reg pu", 3, 0);
        expect_val("R4", "reg pd", 4, 1);
        wr(32'h0000_C000);
        expect_val("R4", "reg pu only", 3, 1);
        expect_val("R4", "reg pd off", 4, 0);

        // R5 pull-down priority
        wr(32'h0000_E000);
        expect_val("R5", "reg both pu", 3, 0);
        expect_val("R5", "reg both pd", 4, 1);
        func_pd = 8'h01;
        wr(32'h0000_0000);
        expect_val("R5", "func both pu", 3, 0);
        expect_val("R5", "func both pd", 4, 1);

        // R7 rising edge, R9 wake gating
        wr(32'h0000_0010);
        pad_in = 1'b1;
        cyc(2);
        expect_val("R7", "pending not yet", 6, 0);
        cyc(1);
        expect_val("R7", "pending on rise", 6, 1);
        expect_val("R9", "wake gated off", 7, 0);
        cyc(1);
        wake_en = 1'b1;
        cyc(1);
        expect_val("R9", "wake on", 7, 1);
        pad_in = 1'b0;
        cyc(4);
        expect_val("R7", "pending sticky", 6, 1);

        // R8 clear
        wr(32'h0000_0050);
        cyc(1);
        expect_val("R8", "cleared", 6, 0);
        expect_val("R9", "wake after clear", 7, 0);
        pad_in = 1'b1;
        cyc(4);
        expect_val("R8", "blocked rise", 6, 0);

        // R7 falling only
        wr(32'h0000_0020);
        cyc(3);
        expect_val("R7", "rise ignored by fall-only", 6, 0);
        pad_in = 1'b0;
        cyc(3);
        expect_val("R7", "pending on fall", 6, 1);
        wake_en = 1'b0;
        cyc(1);
        expect_val("R9", "wake dropped", 7, 0);

        // R7 both edges
        wr(32'h0000_0060);
        wr(32'h0000_0030);
        cyc(1);
        expect_val("R8", "cleared before both", 6, 0);
        pad_in = 1'b1;
        cyc(3);
        expect_val("R7", "both: rise", 6, 1);
        wr(32'h0000_0070);
        cyc(1);
        expect_val("R8", "clear with enables", 6, 0);
        wr(32'h0000_0030);
        pad_in = 1'b0;
        cyc(3);
        expect_val("R7", "both: fall", 6, 1);

        cyc(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule